// File: doc/BRIEF.md
# In-Band Xon/Xoff Transmit Flow Controller

This block applies software flow control to the transmit side of one serial channel. It watches every character that the receive path writes into its receive FIFO and compares it with two programmable control characters, one that pauses the far end's traffic toward this side ("stop") and one that lets it continue ("go"). In automatic mode a received stop character closes the transmit gate and a received go character opens it again. The serializer samples the gate only between characters, so the character already on the line always completes.

The host can also steer the transmitter directly. It can force a halt, lift a host halt, ask for a go or stop character to be sent ahead of any queued FIFO data, and withdraw such a request before it is sent. A two-bit status word reports what the transmitter is doing. Every recognised control character sets a sticky event flag and raises the interrupt line until the flags are read.

Top module: `flowctl_xonxoff`

## Requirements
- R1: After reset the gate is open (`tx_gate`=1), no control character is requested (`ctl_req`=0), `evt_flags`=00 and `irq`=0.
- R2: With `auto_en`=1, a receive write whose data equals `stop_char` closes `tx_gate` from the next cycle. A further stop character while halted leaves the gate closed.
- R3: With `auto_en`=1, a receive write whose data equals `go_char` lifts the halt from the next cycle.
- R4: With `auto_en`=0, received characters never change the halt state.
- R5: The command `cmd_op`=0 (host halt), given with `cmd_valid`=1, sets the halt in either mode.
- R6: The command `cmd_op`=1 (resume) lifts the halt only when `auto_en`=0. In automatic mode it has no effect.
- R7: When a halt source and a release source act in the same cycle, the halt wins.
- R8: Commands `cmd_op`=2 (send go) and `cmd_op`=3 (send stop) make a character pending. `ctl_req`=1 and `ctl_is_go` shows which character it is (1 for go). A later send command replaces the earlier one. The request is raised even while halted, and `tx_gate` is 0 while a request is pending.
- R9: `ctl_ack`=1 clears the pending request. A send command in the same cycle takes precedence over the clear.
- R10: The command `cmd_op`=4 (cancel) withdraws a pending request.
- R11: `tx_state` reads 11 when a go character is pending and 10 when a stop character is pending. Otherwise it reads 01 when halted or when `tx_fifo_empty`=1, and 00 in all other cases.
- R12: A receive write matching `go_char` sets `evt_flags[0]` and one matching `stop_char` sets `evt_flags[1]`, in either mode and whatever the halt state. `irq` is the OR of the flags. `evt_rd`=1 clears both flags, but an event in the same cycle as the read leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic flow-control mode |
| go_char | input | DATA_W | Character that releases the transmitter |
| stop_char | input | DATA_W | Character that halts the transmitter |
| rx_wr | input | 1 | Character written into the receive FIFO |
| rx_data | input | DATA_W | Data of that character |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 3 | Host command code |
| ctl_ack | input | 1 | Serializer took the pending control character |
| tx_fifo_empty | input | 1 | Transmit FIFO holds no data |
| evt_rd | input | 1 | Read of the event flags, which clears them |
| tx_gate | output | 1 | Serializer may take the next FIFO character |
| ctl_req | output | 1 | A control character is to be sent |
| ctl_is_go | output | 1 | The pending character is the go character |
| tx_state | output | 2 | Encoded transmitter status |
| evt_flags | output | 2 | Sticky go/stop recognition flags |
| irq | output | 1 | Interrupt request |

## Verification
There are two pairs of functions that can act in the same cycle. The first pair is received-character recognition and a host command. The directed part of the bench applies a go character together with a host halt and expects the gate to stay closed. The second pair is the serializer's acknowledge and a new send command. The bench drives both at once and expects the new request to stay raised with the new character type. The random part draws receive data mostly from the two control characters and issues commands, acknowledges and flag reads independently each cycle, so these collisions and the read-versus-event collision recur many times. Every cycle is judged against a bench model built from the requirements.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_HOST_HALT = 3'd0,
      OP_RESUME    = 3'd1,
      OP_SEND_GO   = 3'd2,
      OP_SEND_STOP = 3'd3,
      OP_CANCEL    = 3'd4
   } flow_op_e;

   typedef enum logic [1:0] {
      TXS_DATA    = 2'b00,
      TXS_IDLE    = 2'b01,
      TXS_PSTOP   = 2'b10,
      TXS_PGO     = 2'b11
   } tx_state_e;

   localparam int IDX_GO   = 0;
   localparam int IDX_STOP = 1;
   localparam int NUM_CTL  = 2;
endpackage

// File: rtl/flowctl_match.sv
module flowctl_match #(
   parameter int DATA_W  = 8,
   parameter int NUM_CMP = 2
) (
   input  logic                      rx_wr,
   input  logic [DATA_W-1:0]         rx_data,
   input  logic [NUM_CMP*DATA_W-1:0] cmp_chars,
   output logic [NUM_CMP-1:0]        hit
);
   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      assign hit[i] = rx_wr && (rx_data == cmp_chars[i*DATA_W +: DATA_W]);
   end
endmodule

// File: rtl/flowctl_halt.sv
module flowctl_halt (
   input  logic clk,
   input  logic rst_n,
   input  logic set_src,
   input  logic clr_src,
   output logic halted
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       halted <= 1'b0;
      else if (set_src) halted <= 1'b1;
      else if (clr_src) halted <= 1'b0;
   end
endmodule

// File: rtl/flowctl_ctlq.sv
module flowctl_ctlq (
   input  logic clk,
   input  logic rst_n,
   input  logic load_go,
   input  logic load_stop,
   input  logic drop,
   output logic pend,
   output logic pend_go
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         pend_go <= 1'b0;
      end else if (load_go || load_stop) begin
         pend    <= 1'b1;
         pend_go <= load_go;
      end else if (drop) begin
         pend    <= 1'b0;
         pend_go <= 1'b0;
      end
   end
endmodule

// File: rtl/flowctl_xonxoff.sv
module flowctl_xonxoff
   import flowctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_en,
   input  logic [DATA_W-1:0] go_char,
   input  logic [DATA_W-1:0] stop_char,
   input  logic              rx_wr,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic              ctl_ack,
   input  logic              tx_fifo_empty,
   input  logic              evt_rd,
   output logic              tx_gate,
   output logic              ctl_req,
   output logic              ctl_is_go,
   output logic [1:0]        tx_state,
   output logic [1:0]        evt_flags,
   output logic              irq
);
   localparam int CMP_W = NUM_CTL * DATA_W;

   initial begin
      assert (DATA_W >= 5 && DATA_W <= 9)
         else $error("flowctl_xonxoff: DATA_W must lie in 5..9");
   end

   logic [NUM_CTL-1:0] hit;
   logic [CMP_W-1:0]   cmp_chars;
   logic               halted, pend, pend_go;
   logic               op_halt, op_resume, op_go, op_stop, op_cancel;
   logic [1:0]         flags_q;

   assign cmp_chars = {stop_char, go_char};

   flowctl_match #(.DATA_W(DATA_W), .NUM_CMP(NUM_CTL)) u_match (
      .rx_wr     (rx_wr),
      .rx_data   (rx_data),
      .cmp_chars (cmp_chars),
      .hit       (hit)
   );

   assign op_halt   = cmd_valid && (cmd_op == OP_HOST_HALT);
   assign op_resume = cmd_valid && (cmd_op == OP_RESUME);
   assign op_go     = cmd_valid && (cmd_op == OP_SEND_GO);
   assign op_stop   = cmd_valid && (cmd_op == OP_SEND_STOP);
   assign op_cancel = cmd_valid && (cmd_op == OP_CANCEL);

   flowctl_halt u_halt (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_src (op_halt || (auto_en && hit[IDX_STOP])),
      .clr_src ((auto_en && hit[IDX_GO]) || (op_resume && !auto_en)),
      .halted  (halted)
   );

   flowctl_ctlq u_ctlq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_go   (op_go),
      .load_stop (op_stop),
      .drop      (op_cancel || ctl_ack),
      .pend      (pend),
      .pend_go   (pend_go)
   );

   // Sticky recognition flags: a new event beats a clearing read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= hit | (flags_q & {2{!evt_rd}});
   end

   always_comb begin
      if (pend)                         tx_state = pend_go ? TXS_PGO : TXS_PSTOP;
      else if (halted || tx_fifo_empty) tx_state = TXS_IDLE;
      else                              tx_state = TXS_DATA;
   end

   assign tx_gate   = !halted && !pend;
   assign ctl_req   = pend;
   assign ctl_is_go = pend && pend_go;
   assign evt_flags = flags_q;
   assign irq       = |flags_q;
endmodule

// File: rtl/flowctl_xonxoff_chk.sv
module flowctl_xonxoff_chk
   import flowctl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              auto_en,
   input logic [DATA_W-1:0] go_char,
   input logic [DATA_W-1:0] stop_char,
   input logic              rx_wr,
   input logic [DATA_W-1:0] rx_data,
   input logic              cmd_valid,
   input logic [2:0]        cmd_op,
   input logic              ctl_ack,
   input logic              evt_rd,
   input logic              tx_gate,
   input logic              ctl_req,
   input logic              ctl_is_go,
   input logic [1:0]        tx_state,
   input logic [1:0]        evt_flags,
   input logic              irq
);
   a_r2_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && rx_wr && rx_data == stop_char) |=> !tx_gate);

   a_r3_go_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && rx_wr && rx_data == go_char && rx_data != stop_char
       && !(cmd_valid && cmd_op == OP_HOST_HALT)) |=> (tx_gate == !ctl_req));

   a_r6_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && cmd_valid && cmd_op == OP_RESUME && !rx_wr && !tx_gate && !ctl_req
       && !ctl_ack) |=> !tx_gate);

   a_r8_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_req |-> !tx_gate);

   a_r10_cancel_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_CANCEL) |=> !ctl_req);

   a_r11_state_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_state[1] == ctl_req) && (!ctl_req || tx_state[0] == ctl_is_go));

   a_r12_go_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wr && rx_data == go_char) |=> evt_flags[0] && irq);

   a_r12_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wr && rx_data == stop_char) |=> evt_flags[1] && irq);
endmodule

bind flowctl_xonxoff flowctl_xonxoff_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/flowctl_xonxoff_tb.sv
module flowctl_xonxoff_tb;
   localparam logic [7:0] GO = 8'h11;
   localparam logic [7:0] ST = 8'h13;

   logic clk = 1'b0, rst_n = 1'b0;
   logic auto_en = 1'b0, rx_wr = 1'b0, cmd_valid = 1'b0, ctl_ack = 1'b0;
   logic tx_fifo_empty = 1'b1, evt_rd = 1'b0;
   logic [7:0] rx_data = '0;
   logic [2:0] cmd_op = '0;
   logic tx_gate, ctl_req, ctl_is_go, irq;
   logic [1:0] tx_state, evt_flags;

   int checks = 0, errors = 0;
   logic m_halt = 0, m_pend = 0, m_pgo = 0;
   logic [1:0] m_flags = 0;

   always #10 clk = ~clk;

   flowctl_xonxoff #(.DATA_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .go_char(GO), .stop_char(ST),
      .rx_wr(rx_wr), .rx_data(rx_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .ctl_ack(ctl_ack), .tx_fifo_empty(tx_fifo_empty), .evt_rd(evt_rd),
      .tx_gate(tx_gate), .ctl_req(ctl_req), .ctl_is_go(ctl_is_go),
      .tx_state(tx_state), .evt_flags(evt_flags), .irq(irq));

   task automatic expect_v(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_state();
      if (m_pend) return {1'b1, m_pgo};
      if (m_halt || tx_fifo_empty) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check_all();
      expect_v("R7 gate", tx_gate, !m_halt && !m_pend);
      expect_v("R8 req", ctl_req, m_pend);
      expect_v("R8 type", ctl_is_go, m_pend && m_pgo);
      expect_v("R11 state", tx_state, exp_state());
      expect_v("R12 flags", evt_flags, m_flags);
      expect_v("R12 irq", irq, |m_flags);
   endtask

   // Drive one cycle of inputs, advance the model, sample after the edge.
   task automatic step(input logic a, input logic rv, input logic [7:0] rd,
                       input logic cv, input logic [2:0] op, input logic ak,
                       input logic rdc, input logic emp);
      logic gh, sh, set_h, clr_h;
      auto_en = a; rx_wr = rv; rx_data = rd; cmd_valid = cv; cmd_op = op;
      ctl_ack = ak; evt_rd = rdc; tx_fifo_empty = emp;
      gh = rv && rd == GO;
      sh = rv && rd == ST;
      set_h = (a && sh) || (cv && op == 3'd0);
      clr_h = (a && gh) || (cv && op == 3'd1 && !a);
      if (set_h) m_halt = 1'b1; else if (clr_h) m_halt = 1'b0;
      if (cv && (op == 3'd2 || op == 3'd3)) begin m_pend = 1'b1; m_pgo = (op == 3'd2); end
      else if ((cv && op == 3'd4) || ak) begin m_pend = 1'b0; m_pgo = 1'b0; end
      m_flags = {sh, gh} | (m_flags & {2{!rdc}});
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle(input logic a, input logic emp);
      step(a, 0, 8'h00, 0, 3'd0, 0, 0, emp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int pick;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      expect_v("R1 gate", tx_gate, 1);
      expect_v("R1 req", ctl_req, 0);
      expect_v("R1 irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_v("R1 flags", evt_flags, 0);
      check_all();

      idle(1, 0);
      expect_v("R11 data", tx_state, 2'b00);
      step(1, 1, ST, 0, 0, 0, 0, 0);
      expect_v("R2 closed", tx_gate, 0);
      expect_v("R12 stop flag", evt_flags, 2'b10);
      expect_v("R11 halted idle", tx_state, 2'b01);
      step(1, 1, ST, 0, 0, 0, 0, 0);
      expect_v("R2 repeat stop", tx_gate, 0);
      step(1, 0, 8'h00, 1, 3'd1, 0, 0, 0);
      expect_v("R6 resume ignored in auto", tx_gate, 0);
      step(1, 1, GO, 0, 0, 0, 0, 0);
      expect_v("R3 released", tx_gate, 1);
      idle(1, 0);
      step(1, 0, 8'h00, 0, 0, 0, 1, 0);
      expect_v("R12 read clears", irq, 0);
      step(1, 1, GO, 0, 0, 0, 1, 0);
      expect_v("R12 event beats read", evt_flags, 2'b01);
      step(0, 1, ST, 0, 0, 0, 1, 0);
      expect_v("R4 manual ignores stop", tx_gate, 1);
      expect_v("R12 manual records", evt_flags, 2'b10);
      step(0, 0, 8'h00, 1, 3'd0, 0, 0, 0);
      expect_v("R5 host halt", tx_gate, 0);
      step(0, 1, GO, 0, 0, 0, 0, 0);
      expect_v("R4 manual ignores go", tx_gate, 0);
      step(0, 0, 8'h00, 1, 3'd1, 0, 0, 0);
      expect_v("R6 resume manual", tx_gate, 1);
      step(1, 1, GO, 1, 3'd0, 0, 0, 0);
      expect_v("R7 halt wins", tx_gate, 0);
      step(1, 1, GO, 0, 0, 0, 0, 0);
      expect_v("R3 release after", tx_gate, 1);
      step(0, 0, 8'h00, 1, 3'd0, 0, 0, 0);
      step(0, 0, 8'h00, 1, 3'd2, 0, 0, 0);
      expect_v("R8 req while halted", ctl_req, 1);
      expect_v("R8 go type", ctl_is_go, 1);
      expect_v("R11 go pending", tx_state, 2'b11);
      step(0, 0, 8'h00, 1, 3'd3, 0, 0, 0);
      expect_v("R8 replaced", ctl_is_go, 0);
      expect_v("R11 stop pending", tx_state, 2'b10);
      step(0, 0, 8'h00, 1, 3'd2, 1, 0, 0);
      expect_v("R9 send beats ack", ctl_req, 1);
      expect_v("R9 new type", ctl_is_go, 1);
      step(0, 0, 8'h00, 0, 0, 1, 0, 0);
      expect_v("R9 ack clears", ctl_req, 0);
      step(0, 0, 8'h00, 1, 3'd1, 0, 0, 0);
      step(0, 0, 8'h00, 1, 3'd3, 0, 0, 0);
      expect_v("R8 gate shut by pending", tx_gate, 0);
      step(0, 0, 8'h00, 1, 3'd4, 0, 0, 0);
      expect_v("R10 cancel", ctl_req, 0);
      expect_v("R10 gate back", tx_gate, 1);
      check_all();

      for (int i = 0; i < 4000; i++) begin
         pick = $urandom_range(0, 3);
         rd = (pick == 0) ? GO : (pick == 1) ? ST : 8'($urandom);
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0), rd,
              1'($urandom_range(0, 3) == 0), 3'($urandom_range(0, 5)),
              1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
              1'($urandom_range(0, 1)));
         check_all();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule